// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block turns one SMBus transaction request into the ordered list of byte-level operations that an I2C controller carries out. The request names the kind of transaction, the 7-bit target address, a command byte, up to two bytes of write data, a block length, and two option flags. The sequencer then issues start, send, receive, NACK and end operations to the controller one at a time, waits for each to finish, and checks the target's acknowledge of every start.

When the transaction ends it raises a one-cycle done pulse with an error flag, the received byte or little-endian word, and the number of data bytes moved. Block data is kept in a 32-byte buffer. The host fills this buffer before a block write and reads it back after a block read, through a load port and a peek port. Bit timing, arbitration and packet error checking belong to the controller and are not part of this block.

Top module: `smb_host_seq`

## Requirements
- R1: The controller interface encodes operations as 0 start, 1 send, 2 receive, 3 NACK and 4 end. A start carries {address, direction} on `ctl_wdata`, with direction 1 meaning read. A send carries its byte there. The sequencer holds each operation valid and unchanged until `ctl_done`, and presents no operation while idle.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high only while idle. Transaction kinds are encoded as 0 quick, 1 send byte, 2 receive byte, 3 write byte, 4 read byte, 5 write word, 6 read word, 7 block write and 8 block read. Completion is a single-cycle `done` that carries `err`, `rdata` and `rlen`. After reset the block is idle with `done` low.
- R3: A quick transaction issues a start with direction `req_dir` and then an end, with no data bytes. It reports `rlen` 0.
- R4: Send byte issues start(write), send of `req_wdata[7:0]`, then end. Receive byte issues start(read), one receive, NACK, then end, and returns the byte in `rdata[7:0]`. Each reports `rlen` 1.
- R5: Write byte and write word send the command and then the data bytes, low byte first. Read byte and read word send the command, issue a repeated start with direction read, receive one or two bytes, then NACK and end. A received word is little-endian in `rdata`, and `rlen` is 1 or 2.
- R6: If the first start is not acknowledged, the transaction completes at once with `err` set. No end and no other operation follows, and `rlen` is 0.
- R7: If a repeated start is not acknowledged, an end is issued and the transaction then completes with `err` set and `rlen` 0.
- R8: Block write clamps `req_len` to 32. It sends the command, then the clamped length as a byte only when `req_len_flag` is set, then that many bytes from buffer index 0 upward, then an end. `rlen` is the clamped length.
- R9: Block read takes the maximum as `req_len` clamped to 32. It sends the command and a repeated start only when `req_cmd_flag` is set; otherwise its first start is in the read direction. With `req_len_flag` set, the first received byte is the count, and a count above the maximum becomes 0. Without the flag, the count is the maximum. That many bytes go to buffer indices 0 upward, followed by NACK and end, and `rlen` is the count.
- R10: A kind code above 8 completes with `err` set, `rlen` 0, and no controller operation.
- R11: The buffer load port writes only while the sequencer is idle. A load attempted during a transaction has no effect. The peek port shows the byte at `buf_peek_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 4 | Transaction kind code |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command byte |
| req_dir | input | 1 | Direction for a quick transaction (1 read) |
| req_wdata | input | 16 | Write byte (low half) or word |
| req_len | input | 6 | Block length or block maximum |
| req_len_flag | input | 1 | Block length byte is sent or received |
| req_cmd_flag | input | 1 | Block read sends its command phase |
| buf_load | input | 1 | Write strobe for the block buffer |
| buf_load_idx | input | 5 | Buffer index to write |
| buf_load_data | input | 8 | Byte to write |
| buf_peek_idx | input | 5 | Buffer index to read |
| buf_peek_data | output | 8 | Byte at the read index |
| ctl_valid | output | 1 | Operation presented to the controller |
| ctl_op | output | 3 | Operation code |
| ctl_wdata | output | 8 | Start address/direction or byte to send |
| ctl_done | input | 1 | Operation finished (one cycle) |
| ctl_ack | input | 1 | Target acknowledged the start |
| ctl_rdata | input | 8 | Byte received by a receive operation |
| done | output | 1 | Transaction complete pulse |
| err | output | 1 | Transaction failed (valid with done) |
| rdata | output | 16 | Received byte or word (valid with done) |
| rlen | output | 6 | Data bytes moved (valid with done) |

## Verification
The checker enforces the controller handshake on every cycle: an operation stays stable until it completes, nothing is presented while idle, a NACK is always followed by an end, an end is always followed by completion, and done is a single pulse with an error length of zero. The order of the operations within each transaction framing can only be shown by the bench's scenarios. The same holds for the clamping and rejection of lengths, the little-endian assembly of words, the placement of block bytes in the buffer, and the difference between failing at the first start and failing at the repeated start. The bench covers these by sweeping block lengths, counts and maxima across their whole range and comparing against the operation list it computes itself.

// File: rtl/smb_seq_pkg.sv
// Shared types for the SMBus host sequencer: transaction kinds,
// controller operation codes and sequencer states.
package smb_seq_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        K_QUICK  = 4'd0,
        K_SEND   = 4'd1,
        K_RECV   = 4'd2,
        K_WBYTE  = 4'd3,
        K_RBYTE  = 4'd4,
        K_WWORD  = 4'd5,
        K_RWORD  = 4'd6,
        K_BWRITE = 4'd7,
        K_BREAD  = 4'd8
    } kind_e;

    localparam logic [3:0] KIND_LAST = 4'd8;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_END   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_CMD,
        ST_WLEN,
        ST_WDATA,
        ST_RSTART,
        ST_RCNT,
        ST_RDATA,
        ST_NACK,
        ST_END,
        ST_DONE
    } st_e;

endpackage

// File: rtl/smb_len_rules.sv
// Length rules: clamps a requested block length to the buffer depth and
// replaces a received count that exceeds the maximum with zero.
// Assumes LEN_W can hold BUF_DEPTH.
module smb_len_rules #(
    parameter int BUF_DEPTH = 32,
    parameter int LEN_W     = 6
) (
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic [7:0]       rx_count,
    output logic [LEN_W-1:0] req_clamped,
    output logic [LEN_W-1:0] rx_eff
);
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(BUF_DEPTH);

    // Clamp the requested length to the buffer depth.
    always_comb begin
        req_clamped = (req_len > DEPTH_L) ? DEPTH_L : req_len;
    end

    // Reject a received count larger than the maximum.
    always_comb begin
        if (int'(rx_count) > int'(max_len)) begin
            rx_eff = '0;
        end else begin
            rx_eff = LEN_W'(rx_count);
        end
    end
endmodule

// File: rtl/smb_blk_buf.sv
// Block data buffer: one host write port, one sequencer write port
// (sequencer wins on a clash), two combinational read ports.
// Storage is not reset; contents are defined only after writes.
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_din,
    input  logic             seq_we,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic [7:0]       seq_din,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [7:0]       rd_a_dout,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [7:0]       rd_b_dout
);
    logic [7:0] mem [DEPTH];

    // One storage byte per entry, each with its own write select.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (seq_we && (int'(seq_idx) == g)) begin
                mem[g] <= seq_din;
            end else if (host_we && (int'(host_idx) == g)) begin
                mem[g] <= host_din;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_a_dout = mem[rd_a_idx];
        rd_b_dout = mem[rd_b_idx];
    end
endmodule

// File: rtl/smb_seq_ctl.sv
// Transaction state machine: walks the operation list for each SMBus
// transaction kind, one controller operation per state, advancing on
// ctl_done. Assumes the controller pulses ctl_done for one cycle per
// operation and that ctl_ack/ctl_rdata are valid with it.
module smb_seq_ctl
    import smb_seq_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_cmd,
    input  logic              req_dir,
    input  logic [15:0]       req_wdata,
    input  logic              req_len_flag,
    input  logic              req_cmd_flag,
    input  logic [LEN_W-1:0]  req_clamped,
    input  logic [LEN_W-1:0]  rx_eff,
    output logic [LEN_W-1:0]  max_len,
    output logic              ctl_valid,
    output logic [2:0]        ctl_op,
    output logic [7:0]        ctl_wdata,
    input  logic              ctl_done,
    input  logic              ctl_ack,
    input  logic [7:0]        ctl_rdata,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              done,
    output logic              err,
    output logic [15:0]       rdata,
    output logic [LEN_W-1:0]  rlen
);
    st_e               st_q;
    kind_e             kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        cmd_q;
    logic              rd1_q;
    logic [15:0]       wdata_q;
    logic              lflag_q;
    logic              cflag_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  max_q;
    logic [LEN_W-1:0]  idx_q;
    logic              err_q;
    logic [15:0]       rdata_q;

    logic [LEN_W-1:0]  cnt_init;
    logic              rd1_init;
    logic              kind_ok;
    logic              last_byte;
    st_e               rd_body, wr_body, nx_start, nx_cmd, nx_rstart;

    // Data-byte count and first-start direction for an incoming request.
    always_comb begin
        kind_ok  = (req_kind <= KIND_LAST);
        rd1_init = (req_kind == K_RECV) || ((req_kind == K_QUICK) && req_dir)
                || ((req_kind == K_BREAD) && !req_cmd_flag);
        case (req_kind)
            K_QUICK:                          cnt_init = '0;
            K_SEND, K_RECV, K_WBYTE, K_RBYTE: cnt_init = LEN_W'(1);
            K_WWORD, K_RWORD:                 cnt_init = LEN_W'(2);
            default:                          cnt_init = req_clamped;
        endcase
    end

    // Successor states for each branch point of the framings.
    always_comb begin
        last_byte = ((idx_q + LEN_W'(1)) == cnt_q);
        rd_body   = lflag_q ? ST_RCNT : ((cnt_q == '0) ? ST_NACK : ST_RDATA);
        wr_body   = (cnt_q == '0) ? ST_END : ST_WDATA;
        case (kind_q)
            K_QUICK: nx_start = ST_END;
            K_SEND:  nx_start = ST_WDATA;
            K_RECV:  nx_start = ST_RDATA;
            K_BREAD: nx_start = cflag_q ? ST_CMD : rd_body;
            default: nx_start = ST_CMD;
        endcase
        case (kind_q)
            K_WBYTE, K_WWORD: nx_cmd = ST_WDATA;
            K_BWRITE:         nx_cmd = lflag_q ? ST_WLEN : wr_body;
            default:          nx_cmd = ST_RSTART;
        endcase
        nx_rstart = (kind_q == K_BREAD) ? rd_body : ST_RDATA;
    end

    // Sequencer state and transaction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= K_QUICK;
            addr_q  <= '0;
            cmd_q   <= '0;
            rd1_q   <= 1'b0;
            wdata_q <= '0;
            lflag_q <= 1'b0;
            cflag_q <= 1'b0;
            cnt_q   <= '0;
            max_q   <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= kind_e'(req_kind);
                        addr_q  <= req_addr;
                        cmd_q   <= req_cmd;
                        rd1_q   <= rd1_init;
                        wdata_q <= req_wdata;
                        lflag_q <= req_len_flag;
                        cflag_q <= req_cmd_flag;
                        cnt_q   <= cnt_init;
                        max_q   <= req_clamped;
                        idx_q   <= '0;
                        rdata_q <= '0;
                        err_q   <= !kind_ok;
                        st_q    <= kind_ok ? ST_START : ST_DONE;
                    end
                end
                ST_START: begin
                    if (ctl_done) begin
                        if (!ctl_ack) begin
                            err_q <= 1'b1;
                            st_q  <= ST_DONE;
                        end else begin
                            st_q  <= nx_start;
                        end
                    end
                end
                ST_CMD: begin
                    if (ctl_done) st_q <= nx_cmd;
                end
                ST_WLEN: begin
                    if (ctl_done) st_q <= wr_body;
                end
                ST_WDATA: begin
                    if (ctl_done) begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (last_byte) st_q <= ST_END;
                    end
                end
                ST_RSTART: begin
                    if (ctl_done) begin
                        if (!ctl_ack) begin
                            err_q <= 1'b1;
                            st_q  <= ST_END;
                        end else begin
                            st_q  <= nx_rstart;
                        end
                    end
                end
                ST_RCNT: begin
                    if (ctl_done) begin
                        cnt_q <= rx_eff;
                        st_q  <= (rx_eff == '0) ? ST_NACK : ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (ctl_done) begin
                        if (kind_q != K_BREAD) begin
                            if (idx_q[0]) rdata_q[15:8] <= ctl_rdata;
                            else          rdata_q[7:0]  <= ctl_rdata;
                        end
                        idx_q <= idx_q + LEN_W'(1);
                        if (last_byte) st_q <= ST_NACK;
                    end
                end
                ST_NACK: begin
                    if (ctl_done) st_q <= ST_END;
                end
                ST_END: begin
                    if (ctl_done) st_q <= ST_DONE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Controller operation presented in each state.
    always_comb begin
        ctl_valid = 1'b1;
        ctl_wdata = '0;
        case (st_q)
            ST_START:  begin ctl_op = OP_START; ctl_wdata = {addr_q, rd1_q}; end
            ST_RSTART: begin ctl_op = OP_START; ctl_wdata = {addr_q, 1'b1}; end
            ST_CMD:    begin ctl_op = OP_SEND;  ctl_wdata = cmd_q; end
            ST_WLEN:   begin ctl_op = OP_SEND;  ctl_wdata = 8'(cnt_q); end
            ST_WDATA: begin
                ctl_op = OP_SEND;
                if (kind_q == K_BWRITE) ctl_wdata = buf_rdata;
                else                    ctl_wdata = idx_q[0] ? wdata_q[15:8] : wdata_q[7:0];
            end
            ST_RCNT, ST_RDATA: ctl_op = OP_RECV;
            ST_NACK:   ctl_op = OP_NACK;
            ST_END:    ctl_op = OP_END;
            default: begin
                ctl_op    = OP_END;
                ctl_valid = 1'b0;
            end
        endcase
    end

    // Buffer access and result outputs.
    always_comb begin
        buf_we    = (st_q == ST_RDATA) && ctl_done && (kind_q == K_BREAD);
        buf_idx   = idx_q[IDX_W-1:0];
        buf_wdata = ctl_rdata;
        req_ready = (st_q == ST_IDLE);
        max_len   = max_q;
        done      = (st_q == ST_DONE);
        err       = err_q;
        rdata     = rdata_q;
        rlen      = err_q ? '0 : idx_q;
    end
endmodule

// File: rtl/smb_host_seq.sv
// SMBus host transaction sequencer top: joins the length rules, the
// block buffer and the state machine. The host buffer port is gated so
// it only writes while no transaction is running.
module smb_host_seq #(
    parameter int BUF_DEPTH = 32,
    parameter int IDX_W     = $clog2(BUF_DEPTH),
    parameter int LEN_W     = $clog2(BUF_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_kind,
    input  logic [6:0]       req_addr,
    input  logic [7:0]       req_cmd,
    input  logic             req_dir,
    input  logic [15:0]      req_wdata,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_len_flag,
    input  logic             req_cmd_flag,
    input  logic             buf_load,
    input  logic [IDX_W-1:0] buf_load_idx,
    input  logic [7:0]       buf_load_data,
    input  logic [IDX_W-1:0] buf_peek_idx,
    output logic [7:0]       buf_peek_data,
    output logic             ctl_valid,
    output logic [2:0]       ctl_op,
    output logic [7:0]       ctl_wdata,
    input  logic             ctl_done,
    input  logic             ctl_ack,
    input  logic [7:0]       ctl_rdata,
    output logic             done,
    output logic             err,
    output logic [15:0]      rdata,
    output logic [LEN_W-1:0] rlen
);
    logic [LEN_W-1:0] req_clamped, rx_eff, max_len;
    logic             seq_we;
    logic [IDX_W-1:0] seq_idx;
    logic [7:0]       seq_din, seq_rd;
    logic             host_we;

    // Host loads are accepted only while idle.
    always_comb host_we = buf_load && req_ready;

    smb_len_rules #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_len (
        .req_len    (req_len),
        .max_len    (max_len),
        .rx_count   (ctl_rdata),
        .req_clamped(req_clamped),
        .rx_eff     (rx_eff)
    );

    smb_blk_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .host_we  (host_we),
        .host_idx (buf_load_idx),
        .host_din (buf_load_data),
        .seq_we   (seq_we),
        .seq_idx  (seq_idx),
        .seq_din  (seq_din),
        .rd_a_idx (buf_peek_idx),
        .rd_a_dout(buf_peek_data),
        .rd_b_idx (seq_idx),
        .rd_b_dout(seq_rd)
    );

    smb_seq_ctl #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_cmd     (req_cmd),
        .req_dir     (req_dir),
        .req_wdata   (req_wdata),
        .req_len_flag(req_len_flag),
        .req_cmd_flag(req_cmd_flag),
        .req_clamped (req_clamped),
        .rx_eff      (rx_eff),
        .max_len     (max_len),
        .ctl_valid   (ctl_valid),
        .ctl_op      (ctl_op),
        .ctl_wdata   (ctl_wdata),
        .ctl_done    (ctl_done),
        .ctl_ack     (ctl_ack),
        .ctl_rdata   (ctl_rdata),
        .buf_we      (seq_we),
        .buf_idx     (seq_idx),
        .buf_wdata   (seq_din),
        .buf_rdata   (seq_rd),
        .done        (done),
        .err         (err),
        .rdata       (rdata),
        .rlen        (rlen)
    );
endmodule

// File: rtl/smb_host_seq_chk.sv
// Protocol checker for the sequencer's ports, attached by bind.
// Assumes a synchronous active-low reset.
module smb_host_seq_chk #(
    parameter int BUF_DEPTH = 32,
    parameter int LEN_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ctl_valid,
    input logic [2:0]       ctl_op,
    input logic [7:0]       ctl_wdata,
    input logic             ctl_done,
    input logic             done,
    input logic             err,
    input logic [LEN_W-1:0] rlen
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ctl_valid);

    p_op_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_done) |=> (ctl_valid && $stable(ctl_op) && $stable(ctl_wdata)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_end_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 3'd4 && ctl_done) |=> done);

    p_err_no_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rlen == '0));

    p_nack_then_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_op == 3'd3 && ctl_done) |=> (ctl_valid && ctl_op == 3'd4));

    p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(rlen) <= BUF_DEPTH));
endmodule

bind smb_host_seq smb_host_seq_chk #(.BUF_DEPTH(BUF_DEPTH), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .ctl_valid(ctl_valid),
    .ctl_op   (ctl_op),
    .ctl_wdata(ctl_wdata),
    .ctl_done (ctl_done),
    .done     (done),
    .err      (err),
    .rlen     (rlen)
);

// File: tb/sim_smb_host_seq.sv
module sim_smb_host_seq;
    localparam int NACK_A = 7'h5A;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic        req_valid = 0, req_dir = 0, req_len_flag = 0, req_cmd_flag = 0;
    logic [3:0]  req_kind = 0;
    logic [6:0]  req_addr = 0;
    logic [7:0]  req_cmd = 0;
    logic [15:0] req_wdata = 0;
    logic [5:0]  req_len = 0;
    logic        buf_load = 0;
    logic [4:0]  buf_load_idx = 0, buf_peek_idx = 0;
    logic [7:0]  buf_load_data = 0;
    logic [7:0]  buf_peek_data;
    logic        req_ready, ctl_valid, done, err;
    logic [2:0]  ctl_op;
    logic [7:0]  ctl_wdata;
    logic        ctl_done = 0, ctl_ack = 0;
    logic [7:0]  ctl_rdata = 0;
    logic [15:0] rdata;
    logic [5:0]  rlen;

    smb_host_seq u0 (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;

    // target model state
    int log_n = 0, st_no = 0, rx_no = 0;
    int log_op [0:127];
    int log_b  [0:127];
    bit m_fail_rs = 0, m_cnt_mode = 0;
    int m_cnt_val = 0;
    logic [6:0] cur_a = 0;

    int exp_op [0:127];
    int exp_b  [0:127];
    int exp_n;

    function automatic logic [7:0] pat(input logic [6:0] a, input int i);
        return 8'(int'(a) * 29 + i * 7 + 3);
    endfunction

    function automatic logic [7:0] img(input int i);
        return 8'(i * 11 + 8'h40);
    endfunction

    // Byte-level target: answers each operation half a cycle after it appears.
    always @(negedge clk) begin
        if (ctl_done) ctl_done <= 0;
        else if (ctl_valid) begin
            log_op[log_n] = int'(ctl_op);
            log_b[log_n]  = (ctl_op <= 3'd1) ? int'(ctl_wdata) : 0;
            log_n++;
            ctl_done <= 1;
            if (ctl_op == 3'd0) begin
                cur_a = ctl_wdata[7:1];
                ctl_ack <= (ctl_wdata[7:1] != 7'(NACK_A)) && !(ctl_wdata[0] && st_no > 0 && m_fail_rs);
                st_no++;
            end else if (ctl_op == 3'd2) begin
                if (m_cnt_mode && rx_no == 0) ctl_rdata <= 8'(m_cnt_val);
                else ctl_rdata <= pat(cur_a, rx_no - (m_cnt_mode ? 1 : 0));
                rx_no++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic push(input int op, input int b);
        exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
    endtask

    // Build the expected operation list, run one transaction, compare.
    task automatic run(input string rq, input int k, input logic [6:0] a, input logic [7:0] c,
                       input bit dir, input logic [15:0] wd, input int len, input bit lf,
                       input bit cf, input bit poke);
        int mx, n, e_len, guard;
        bit e_err, rd1, seq_ok, buf_ok;
        logic [15:0] e_rd;
        mx = (len > 32) ? 32 : len;
        exp_n = 0; e_err = 0; e_len = 0; e_rd = 0; n = 0;
        rd1 = (k == 2) || (k == 0 && dir) || (k == 8 && !cf);
        if (k > 8) e_err = 1;
        else begin
            push(0, {a, rd1});
            if (a == 7'(NACK_A)) e_err = 1;
            else if (k == 0) push(4, 0);
            else if (k == 1) begin push(1, wd[7:0]); push(4, 0); e_len = 1; end
            else if (k == 2) begin push(2, 0); push(3, 0); push(4, 0); e_len = 1; e_rd = {8'h0, pat(a, 0)}; end
            else if (k == 3 || k == 5) begin
                push(1, c); push(1, wd[7:0]); e_len = 1;
                if (k == 5) begin push(1, wd[15:8]); e_len = 2; end
                push(4, 0);
            end else if (k == 7) begin
                push(1, c); if (lf) push(1, mx);
                for (int i = 0; i < mx; i++) push(1, img(i));
                push(4, 0); e_len = mx;
            end else begin
                bit rs_fail;
                rs_fail = 0;
                if (k != 8 || cf) begin
                    push(1, c); push(0, {a, 1'b1});
                    if (m_fail_rs) begin push(4, 0); e_err = 1; rs_fail = 1; end
                end
                if (!rs_fail) begin
                    if (k == 4) begin push(2, 0); e_len = 1; e_rd = {8'h0, pat(a, 0)}; end
                    else if (k == 6) begin push(2, 0); push(2, 0); e_len = 2; e_rd = {pat(a, 1), pat(a, 0)}; end
                    else begin
                        n = mx;
                        if (lf) begin push(2, 0); n = (m_cnt_val > mx) ? 0 : m_cnt_val; end
                        for (int i = 0; i < n; i++) push(2, 0);
                        e_len = n;
                    end
                    push(3, 0); push(4, 0);
                end
            end
        end
        log_n = 0; st_no = 0; rx_no = 0;
        @(negedge clk);
        req_kind = 4'(k); req_addr = a; req_cmd = c; req_dir = dir; req_wdata = wd;
        req_len = 6'(len); req_len_flag = lf; req_cmd_flag = cf; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin buf_load = 1; buf_load_idx = 5'd31; buf_load_data = 8'hEE; end
        guard = 0;
        while (!done && guard < 400) begin
            @(negedge clk); guard++;
            buf_load = 0;
        end
        buf_load = 0;
        check(done === 1'b1, rq, "done seen", int'(done), 1);
        check(err === e_err, rq, "err", int'(err), int'(e_err));
        check(int'(rlen) == e_len, rq, "rlen", int'(rlen), e_len);
        if (!e_err && (k == 2 || k == 4 || k == 6))
            check(rdata === e_rd, rq, "rdata", int'(rdata), int'(e_rd));
        @(negedge clk);
        seq_ok = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_op[i] != exp_op[i] || log_b[i] != exp_b[i]) seq_ok = 0;
        check(seq_ok, rq, "operation list length", log_n, exp_n);
        if (k == 8 && !e_err) begin
            buf_ok = 1;
            for (int i = 0; i < e_len; i++) begin
                buf_peek_idx = 5'(i); #1;
                if (buf_peek_data !== pat(a, i)) buf_ok = 0;
            end
            check(buf_ok, rq, "block read buffer bytes", 0, 0);
        end
    endtask

    task automatic load_img();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            buf_load = 1; buf_load_idx = 5'(i); buf_load_data = img(i);
        end
        @(negedge clk); buf_load = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0 && ctl_valid === 1'b0, "R2", "reset idle state", int'(req_ready), 1);

        // R3 quick both directions, R6 on unacknowledged address
        for (int a = 1; a < 128; a += 21) begin
            run("R3", 0, 7'(a), 8'h00, 0, 0, 0, 0, 0, 0);
            run("R3", 0, 7'(a), 8'h00, 1, 0, 0, 0, 0, 0);
        end
        run("R6", 0, 7'(NACK_A), 8'h00, 1, 0, 0, 0, 0, 0);

        // R4 send byte / receive byte
        for (int v = 0; v < 256; v += 37) begin
            run("R4", 1, 7'(v / 3 + 1), 8'h00, 0, 16'(v), 0, 0, 0, 0);
            run("R4", 2, 7'(v / 3 + 2), 8'h00, 0, 0, 0, 0, 0, 0);
        end

        // R5 byte and word framings, little-endian words
        for (int v = 0; v < 8; v++) begin
            logic [15:0] w;
            w = 16'(v * 16'h2345 + 16'h0180);
            run("R5", 3, 7'h10 + 7'(v), 8'(v * 9), 0, w, 0, 0, 0, 0);
            run("R5", 4, 7'h20 + 7'(v), 8'(v * 5), 0, 0, 0, 0, 0, 0);
            run("R5", 5, 7'h30 + 7'(v), 8'(v * 3), 0, w, 0, 0, 0, 0);
            run("R5", 6, 7'h40 + 7'(v), 8'(v * 7), 0, 0, 0, 0, 0, 0);
        end

        // R6 first-start failure for several kinds
        run("R6", 2, 7'(NACK_A), 8'h00, 0, 0, 0, 0, 0, 0);
        run("R6", 5, 7'(NACK_A), 8'h11, 0, 16'h1234, 0, 0, 0, 0);
        run("R6", 8, 7'(NACK_A), 8'h22, 0, 0, 8, 0, 0, 0);

        // R7 repeated-start failure
        m_fail_rs = 1;
        run("R7", 4, 7'h21, 8'h31, 0, 0, 0, 0, 0, 0);
        run("R7", 6, 7'h22, 8'h32, 0, 0, 0, 0, 0, 0);
        run("R7", 8, 7'h23, 8'h33, 0, 0, 10, 1, 1, 0);
        m_fail_rs = 0;

        // R8 block write: every length, with and without length byte
        load_img();
        for (int l = 0; l <= 40; l++) begin
            run("R8", 7, 7'h44, 8'hA5, 0, 0, l, 0, 0, 0);
            run("R8", 7, 7'h45, 8'h5A, 0, 0, l, 1, 0, 0);
        end

        // R11 load during a transaction is ignored
        run("R11", 7, 7'h46, 8'h77, 0, 0, 32, 0, 0, 1);
        buf_peek_idx = 5'd31; #1;
        check(buf_peek_data === img(31), "R11", "byte 31 after busy load", int'(buf_peek_data), int'(img(31)));

        // R9 block read: counts across maxima, both command options
        m_cnt_mode = 1;
        for (int cf = 0; cf < 2; cf++)
            for (int mi = 0; mi < 5; mi++) begin
                int mxv;
                mxv = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 7 : (mi == 3) ? 32 : 45;
                for (int cv = 0; cv <= 41; cv++) begin
                    m_cnt_val = (cv == 41) ? 255 : cv;
                    run("R9", 8, 7'(cv + 3), 8'h5C, 0, 0, mxv, 1, cf[0], 0);
                end
            end
        m_cnt_mode = 0;
        for (int cf = 0; cf < 2; cf++)
            for (int l = 0; l <= 34; l++)
                run("R9", 8, 7'(l + 60), 8'h6D, 0, 0, l, 0, cf[0], 0);

        // R10 undefined kind codes
        for (int k = 9; k < 16; k++)
            run("R10", k, 7'h12, 8'h00, 0, 0, 4, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule